// File: doc/BRIEF.md
# YCbCr-to-RGB Matrix Colour Converter

This block turns a stream of luma and chroma samples into packed RGB pixels. Every accepted beat carries one Y, one Cb and one Cr sample of 8 bits each. The block removes a programmable footroom from Y and centres both chroma samples on 128. It then multiplies the resulting vector by a programmable 3x3 matrix of signed fixed-point coefficients. Each of the three sums is rounded, saturated to 8 bits and packed into one of four pixel layouts.

Software sets up the block through a small write port. That port holds the coefficients, the footroom, the output layout and the base address of the source buffer. A start pulse checks the source address against three allowed address spans. If the address lies inside one of them, the stream is opened. If it does not, an error flag is raised and no beat is accepted. Memory fetching, chroma upsampling and plane addressing are done outside this block. The destination address is not checked at all, so the block does not store it.

Both stream ports use valid/ready handshaking. The pipeline has three register stages and stalls as a whole when the consumer deasserts ready.

Top module: `ycc_rgb_conv`

## Requirements
- R1: After a synchronous reset, `out_valid`, `in_ready`, `busy` and `src_err` are all 0. The footroom is 0 and the output layout is code 0.
- R2: Write select 8 holds the source address. A `start` pulse opens the stream only if that address lies in one of three half-open spans: [0x00000000,0x00400000), [0x04000000,0x04200000) or [0x08300000,0x0C000000). On the edge of the pulse, a legal address gives `busy`=1 and `src_err`=0. An illegal address gives `src_err`=1 and `busy`=0, and from then on `in_ready` stays 0, no beat is accepted and no pixel comes out.
- R3: Row r of the matrix is 48 bits wide. Its low word is written at select 2r and its bits [47:32] at select 2r+1 (data bits [15:0]). Coefficient k of the row sits at row bits [16k+9:16k] and is a 10-bit two's-complement value with 7 fraction bits. Rows 0, 1 and 2 produce R, G and B. Coefficients 0, 1 and 2 multiply (Y - footroom), (Cb - 128) and (Cr - 128).
- R4: Write select 6 bits [7:0] hold the footroom. It is subtracted from Y before the multiply, and a negative difference flows on as a signed value.
- R5: Each channel is computed as (sum + 64) >>> 7 and then clamped to the range 0..255.
- R6: Write select 7 bits [1:0] choose the output layout. Code 0 gives {R,G,B,8'hFF} in 32 bits. Code 1 gives {R[7:3],G[7:2],B[7:3]}. Code 2 gives {R[7:3],G[7:3],B[7:3],1'b1}. Code 3 gives {R[7:4],G[7:4],B[7:4],4'hF}. The 16-bit codes place the pixel in bits [15:0] with bits [31:16] zero.
- R7: A beat accepted on clock edge k shows `out_valid` after edge k+2 when the output is not stalled. Pixels leave in the order their beats were accepted, and none is lost or duplicated.
- R8: While `out_valid`=1 and `out_ready`=0, `in_ready` is 0, and on the next cycle `out_valid` stays 1 with `out_pix` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 4 | Configuration word select |
| cfg_data | input | 32 | Configuration write data |
| start | input | 1 | Check the source address and open or refuse the stream |
| busy | output | 1 | Stream open |
| src_err | output | 1 | Last start saw an illegal source address |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted this cycle |
| in_y | input | 8 | Luma sample |
| in_cb | input | 8 | Blue-difference sample |
| in_cr | input | 8 | Red-difference sample |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Consumer ready |
| out_pix | output | 32 | Packed output pixel |

## Verification
The bench tests the address check one step on each side of every span edge. A design that treated an upper bound as inclusive, or wrote a bound wrongly, would open the stream where it should refuse it, or the reverse. The rounding tests feed exact half-way sums and negative sums. A design that truncated, shifted logically or clamped before rounding would return a value one step off or wrap a negative result to a large one. Several tests depend on the coefficient lanes. Giving the third coefficient a negative value exposes a wrong lane, a missing sign extension or a missing chroma offset, and a wrong footroom subtraction shows up as a shifted luma. Streams run with a ready pattern full of gaps, so any stage that does not freeze drops a pixel, repeats one or changes `out_pix` during a stall.

// File: rtl/csc_pkg.sv
package csc_pkg;

  localparam int N_ROWS   = 3;
  localparam int LANE_W   = 16;
  localparam int N_SPAN   = 3;
  localparam int SEL_FOOT = 6;
  localparam int SEL_FMT  = 7;
  localparam int SEL_SRC  = 8;

  // Source buffer spans, lower bound inclusive, upper bound exclusive
  localparam logic [31:0] SPAN_LO [N_SPAN] = '{32'h0000_0000, 32'h0400_0000, 32'h0830_0000};
  localparam logic [31:0] SPAN_HI [N_SPAN] = '{32'h0040_0000, 32'h0420_0000, 32'h0C00_0000};

  typedef enum logic [1:0] {
    FMT_RGBA32   = 2'd0,
    FMT_RGB565   = 2'd1,
    FMT_RGBA5551 = 2'd2,
    FMT_RGBA4444 = 2'd3
  } pix_fmt_e;

endpackage

// File: rtl/csc_cfg_regs.sv
module csc_cfg_regs
  import csc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SEL_W  = 4,
  parameter int COEF_W = 10,
  parameter int FOOT_W = 8
) (
  input  logic                                       clk,
  input  logic                                       rst,
  input  logic                                       wr_en,
  input  logic [SEL_W-1:0]                           wr_sel,
  input  logic [DATA_W-1:0]                          wr_data,
  input  logic                                       start,
  output logic [N_ROWS-1:0][N_ROWS-1:0][COEF_W-1:0]  coef_o,
  output logic [FOOT_W-1:0]                          foot_q,
  output pix_fmt_e                                   fmt_q,
  output logic                                       running_q,
  output logic                                       err_q
);

  localparam int LO_N = DATA_W / LANE_W;

  logic [COEF_W-1:0] coef_q [N_ROWS][N_ROWS];
  logic [DATA_W-1:0] src_q;
  logic [N_SPAN-1:0] span_hit;
  logic              src_ok;

  // One register per coefficient, each decoding its own word and lane
  for (genvar r = 0; r < N_ROWS; r++) begin : g_row
    for (genvar k = 0; k < N_ROWS; k++) begin : g_coef
      localparam int WORD = (k < LO_N) ? 0 : 1;
      localparam int BASE = (k - WORD * LO_N) * LANE_W;
      localparam int SEL  = 2 * r + WORD;
      always_ff @(posedge clk) begin
        if (rst) begin
          coef_q[r][k] <= '0;
        end else if (wr_en && wr_sel == SEL_W'(SEL)) begin
          coef_q[r][k] <= wr_data[BASE +: COEF_W];
        end
      end
      assign coef_o[r][k] = coef_q[r][k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      foot_q <= '0;
      fmt_q  <= FMT_RGBA32;
      src_q  <= '0;
    end else if (wr_en) begin
      if (wr_sel == SEL_W'(SEL_FOOT)) foot_q <= wr_data[FOOT_W-1:0];
      if (wr_sel == SEL_W'(SEL_FMT))  fmt_q  <= pix_fmt_e'(wr_data[1:0]);
      if (wr_sel == SEL_W'(SEL_SRC))  src_q  <= wr_data;
    end
  end

  for (genvar g = 0; g < N_SPAN; g++) begin : g_span
    assign span_hit[g] = (src_q >= SPAN_LO[g]) && (src_q < SPAN_HI[g]);
  end
  assign src_ok = |span_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      running_q <= 1'b0;
      err_q     <= 1'b0;
    end else if (start) begin
      running_q <= src_ok;
      err_q     <= !src_ok;
    end
  end

  assert_start_legal_R2: assert property (@(posedge clk) disable iff (rst)
    (start && src_ok) |=> (running_q && !err_q));

  assert_start_illegal_R2: assert property (@(posedge clk) disable iff (rst)
    (start && !src_ok) |=> (err_q && !running_q));

  assert_state_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !start |=> ($stable(running_q) && $stable(err_q)));

endmodule

// File: rtl/csc_row_mac.sv
module csc_row_mac
  import csc_pkg::*;
#(
  parameter int COEF_W = 10,
  parameter int OPD_W  = 10,
  parameter int FRAC_W = 7,
  parameter int CH_W   = 8
) (
  input  logic                             clk,
  input  logic                             en,
  input  logic [N_ROWS-1:0][COEF_W-1:0]    coef,
  input  logic [N_ROWS-1:0][OPD_W-1:0]     opd,
  output logic [CH_W-1:0]                  chan_o
);

  localparam int PROD_W = COEF_W + OPD_W;
  localparam int SUM_W  = PROD_W + 2;
  localparam int HALF_I = 1 << (FRAC_W - 1);
  localparam logic signed [SUM_W-1:0] HALF   = SUM_W'(HALF_I);
  localparam logic signed [SUM_W-1:0] CH_MAX = SUM_W'((1 << CH_W) - 1);

  logic signed [PROD_W-1:0] prod [N_ROWS];
  logic signed [SUM_W-1:0]  sum_d;
  logic signed [SUM_W-1:0]  sum_q;
  logic signed [SUM_W-1:0]  rnd;
  logic signed [SUM_W-1:0]  shifted;

  always_comb begin
    sum_d = '0;
    for (int k = 0; k < N_ROWS; k++) begin
      prod[k] = $signed(coef[k]) * $signed(opd[k]);
      sum_d   = sum_d + $signed({{(SUM_W-PROD_W){prod[k][PROD_W-1]}}, prod[k]});
    end
  end

  // Stage 2: hold the dot product
  always_ff @(posedge clk) begin
    if (en) sum_q <= sum_d;
  end

  // Rounding and saturation feed the stage-3 packer
  always_comb begin
    rnd     = sum_q + HALF;
    shifted = rnd >>> FRAC_W;
    if (shifted < 0) begin
      chan_o = '0;
    end else if (shifted > CH_MAX) begin
      chan_o = '1;
    end else begin
      chan_o = shifted[CH_W-1:0];
    end
  end

endmodule

// File: rtl/csc_pixel_pack.sv
module csc_pixel_pack
  import csc_pkg::*;
#(
  parameter int CH_W  = 8,
  parameter int PIX_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              valid_i,
  input  pix_fmt_e          fmt,
  input  logic [CH_W-1:0]   red,
  input  logic [CH_W-1:0]   grn,
  input  logic [CH_W-1:0]   blu,
  output logic              valid_q,
  output logic [PIX_W-1:0]  pix_q
);

  logic [PIX_W-1:0] pix_d;

  always_comb begin
    case (fmt)
      FMT_RGB565:   pix_d = PIX_W'({red[CH_W-1 -: 5], grn[CH_W-1 -: 6], blu[CH_W-1 -: 5]});
      FMT_RGBA5551: pix_d = PIX_W'({red[CH_W-1 -: 5], grn[CH_W-1 -: 5], blu[CH_W-1 -: 5], 1'b1});
      FMT_RGBA4444: pix_d = PIX_W'({red[CH_W-1 -: 4], grn[CH_W-1 -: 4], blu[CH_W-1 -: 4], 4'hF});
      default:      pix_d = PIX_W'({red, grn, blu, {CH_W{1'b1}}});
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      pix_q   <= '0;
    end else if (en) begin
      valid_q <= valid_i;
      if (valid_i) pix_q <= pix_d;
    end
  end

endmodule

// File: rtl/ycc_rgb_conv.sv
module ycc_rgb_conv
  import csc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SEL_W  = 4,
  parameter int CH_W   = 8,
  parameter int COEF_W = 10,
  parameter int FRAC_W = 7,
  parameter int PIX_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic [SEL_W-1:0]  cfg_sel,
  input  logic [DATA_W-1:0] cfg_data,
  input  logic              start,
  output logic              busy,
  output logic              src_err,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [CH_W-1:0]   in_y,
  input  logic [CH_W-1:0]   in_cb,
  input  logic [CH_W-1:0]   in_cr,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [PIX_W-1:0]  out_pix
);

  localparam int OPD_W = CH_W + 2;
  localparam int MID   = 1 << (CH_W - 1);

  logic [N_ROWS-1:0][N_ROWS-1:0][COEF_W-1:0] coef;
  logic [CH_W-1:0]                           foot;
  pix_fmt_e                                  fmt;

  csc_cfg_regs #(
    .DATA_W (DATA_W),
    .SEL_W  (SEL_W),
    .COEF_W (COEF_W),
    .FOOT_W (CH_W)
  ) u_cfg (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (cfg_wr),
    .wr_sel    (cfg_sel),
    .wr_data   (cfg_data),
    .start     (start),
    .coef_o    (coef),
    .foot_q    (foot),
    .fmt_q     (fmt),
    .running_q (busy),
    .err_q     (src_err)
  );

  // One enable for all stages: move when the output slot frees up
  logic adv;
  logic take;
  logic v1;
  logic v2;
  logic [N_ROWS-1:0][OPD_W-1:0] opd1;

  assign adv      = !out_valid || out_ready;
  assign in_ready = busy && adv;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      v1 <= 1'b0;
      v2 <= 1'b0;
    end else if (adv) begin
      v1 <= take;
      v2 <= v1;
    end
  end

  // Stage 1: remove footroom and chroma midpoint
  always_ff @(posedge clk) begin
    if (rst) begin
      opd1 <= '0;
    end else if (take) begin
      opd1[0] <= OPD_W'(in_y)  - OPD_W'(foot);
      opd1[1] <= OPD_W'(in_cb) - OPD_W'(MID);
      opd1[2] <= OPD_W'(in_cr) - OPD_W'(MID);
    end
  end

  logic [N_ROWS-1:0][CH_W-1:0] chan;

  for (genvar r = 0; r < N_ROWS; r++) begin : g_mac
    csc_row_mac #(
      .COEF_W (COEF_W),
      .OPD_W  (OPD_W),
      .FRAC_W (FRAC_W),
      .CH_W   (CH_W)
    ) u_mac (
      .clk    (clk),
      .en     (adv),
      .coef   (coef[r]),
      .opd    (opd1),
      .chan_o (chan[r])
    );
  end

  csc_pixel_pack #(
    .CH_W  (CH_W),
    .PIX_W (PIX_W)
  ) u_pack (
    .clk     (clk),
    .rst     (rst),
    .en      (adv),
    .valid_i (v2),
    .fmt     (fmt),
    .red     (chan[0]),
    .grn     (chan[1]),
    .blu     (chan[2]),
    .valid_q (out_valid),
    .pix_q   (out_pix)
  );

  // Beats between the input and output handshakes
  logic [2:0] inflight;
  always_ff @(posedge clk) begin
    if (rst) inflight <= '0;
    else     inflight <= inflight + 3'(take) - 3'(out_valid && out_ready);
  end

  assert_inflight_R7: assert property (@(posedge clk) disable iff (rst)
    inflight <= 3'd3);

  assert_latency_R7: assert property (@(posedge clk) disable iff (rst)
    take ##1 out_ready ##1 out_ready |=> out_valid);

  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_pix)));

  assert_stall_in_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);

  assert_gate_R2: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> busy);

endmodule

// File: tb/ycc_rgb_conv_bench.sv
module ycc_rgb_conv_bench;

  localparam int CLK_NS = 20;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr = 1'b0;
  logic [3:0]  cfg_sel = '0;
  logic [31:0] cfg_data = '0;
  logic        start = 1'b0;
  logic        busy, src_err;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_y = '0, in_cb = '0, in_cr = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_pix;

  always #(CLK_NS/2) clk = ~clk;

  ycc_rgb_conv u_ycc_rgb_conv (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
    .start(start), .busy(busy), .src_err(src_err),
    .in_valid(in_valid), .in_ready(in_ready), .in_y(in_y), .in_cb(in_cb), .in_cr(in_cr),
    .out_valid(out_valid), .out_ready(out_ready), .out_pix(out_pix)
  );

  int n_chk = 0;
  int n_err = 0;
  logic [9:0] m_coef [3][3];
  int m_foot = 0;
  int m_fmt = 0;
  logic [31:0] expq [$];
  bit mon_on = 1'b0;
  int rdy_mode = 0;
  int cyc = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic int sx(input logic [9:0] c);
    int v;
    v = int'(c);
    if (v >= 512) v -= 1024;
    return v;
  endfunction

  function automatic int chan_m(input int r, input int y, input int cb, input int cr);
    int s, v;
    s = sx(m_coef[r][0]) * (y - m_foot) + sx(m_coef[r][1]) * (cb - 128)
      + sx(m_coef[r][2]) * (cr - 128);
    v = (s + 64) >>> 7;
    if (v < 0) v = 0;
    if (v > 255) v = 255;
    return v;
  endfunction

  function automatic logic [31:0] exp_pix(input int y, input int cb, input int cr);
    logic [7:0] r, g, b;
    r = 8'(chan_m(0, y, cb, cr));
    g = 8'(chan_m(1, y, cb, cr));
    b = 8'(chan_m(2, y, cb, cr));
    case (m_fmt)
      1: return {16'h0, r[7:3], g[7:2], b[7:3]};
      2: return {16'h0, r[7:3], g[7:3], b[7:3], 1'b1};
      3: return {16'h0, r[7:4], g[7:4], b[7:4], 4'hF};
      default: return {r, g, b, 8'hFF};
    endcase
  endfunction

  function automatic bit legal_m(input logic [31:0] a);
    if (a <= 32'h003F_FFFF) return 1'b1;
    if (a >= 32'h0400_0000 && a <= 32'h041F_FFFF) return 1'b1;
    if (a >= 32'h0830_0000 && a <= 32'h0BFF_FFFF) return 1'b1;
    return 1'b0;
  endfunction

  // Consumer ready pattern
  always @(negedge clk) begin
    cyc++;
    out_ready = (rdy_mode == 0) || (cyc % 3 != 0);
  end

  // Scoreboard, sampled just before each rising edge
  logic pv = 1'b0, prdy = 1'b1;
  logic [31:0] ppix = '0;
  always @(negedge clk) begin
    #9;
    if (mon_on) begin
      if (pv && !prdy) begin
        chk("R8 valid held", 32'(out_valid), 32'd1);
        chk("R8 pixel held", out_pix, ppix);
      end
      if (out_valid && !out_ready) chk("R8 input stalled", 32'(in_ready), 32'd0);
      if (out_valid && out_ready) begin
        if (expq.size() == 0) chk("R7 unexpected pixel", out_pix, 32'hDEAD_BEEF);
        else chk("R7 pixel order/value", out_pix, expq.pop_front());
      end
      if (in_valid && in_ready) expq.push_back(exp_pix(int'(in_y), int'(in_cb), int'(in_cr)));
    end
    pv = out_valid;
    prdy = out_ready;
    ppix = out_pix;
  end

  task automatic wr(input int sel, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_sel = 4'(sel); cfg_data = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic set_row(input int r, input int c0, input int c1, input int c2);
    m_coef[r][0] = 10'(c0);
    m_coef[r][1] = 10'(c1);
    m_coef[r][2] = 10'(c2);
    wr(2 * r, {6'b0, 10'(c1), 6'b0, 10'(c0)});
    wr(2 * r + 1, {22'b0, 10'(c2)});
  endtask

  task automatic set_foot(input int f);
    m_foot = f;
    wr(6, 32'(f));
  endtask

  task automatic set_fmt(input int f);
    m_fmt = f;
    wr(7, 32'(f));
  endtask

  task automatic do_start(input logic [31:0] a);
    wr(8, a);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic send(input int y, input int cb, input int cr);
    bit acc;
    in_valid = 1'b1; in_y = 8'(y); in_cb = 8'(cb); in_cr = 8'(cr);
    do begin
      #9;
      acc = in_ready;
      @(negedge clk);
    end while (!acc);
    in_valid = 1'b0;
  endtask

  task automatic one_beat(input string tag, input int y, input int cb, input int cr,
                          input logic [31:0] lit);
    int n;
    @(negedge clk);
    send(y, cb, cr);
    n = 0;
    #1;
    while (!out_valid && n < 10) begin
      @(negedge clk);
      #1;
      n++;
    end
    chk(tag, out_pix, lit);
    @(negedge clk);
  endtask

  task automatic identity_rows();
    set_row(0, 128, 0, 0);
    set_row(1, 0, 128, 0);
    set_row(2, 0, 0, 128);
  endtask

  task automatic test_reset();
    #1;
    chk("R1 out_valid", 32'(out_valid), 0);
    chk("R1 in_ready", 32'(in_ready), 0);
    chk("R1 busy", 32'(busy), 0);
    chk("R1 src_err", 32'(src_err), 0);
  endtask

  task automatic test_range();
    logic [31:0] addrs [10];
    addrs = '{32'h003F_FFFF, 32'h0040_0000, 32'h03FF_FFFF, 32'h0400_0000, 32'h041F_FFFF,
              32'h0420_0000, 32'h082F_FFFF, 32'h0830_0000, 32'h0BFF_FFFF, 32'h0C00_0000};
    for (int i = 0; i < 10; i++) begin
      do_start(addrs[i]);
      #1;
      chk("R2 busy after start", 32'(busy), 32'(legal_m(addrs[i])));
      chk("R2 src_err after start", 32'(src_err), 32'(!legal_m(addrs[i])));
    end
    // Illegal source: beats must be refused and nothing may come out
    do_start(32'hFFFF_0000);
    in_valid = 1'b1; in_y = 8'h55;
    for (int i = 0; i < 6; i++) begin
      #9;
      chk("R2 refused beat", 32'(in_ready), 0);
      @(negedge clk);
      #1;
      chk("R2 no output", 32'(out_valid), 0);
    end
    in_valid = 1'b0;
    do_start(32'h0000_0000);
    #1;
    chk("R2 reopen", 32'(busy), 1);
  endtask

  task automatic test_lanes();
    identity_rows();
    set_foot(0);
    set_fmt(0);
    one_beat("R3 identity", 8'h5A, 8'h90, 8'hF0, 32'h5A1070FF);
    set_row(0, 0, 0, 256);
    set_row(1, 0, -128, 0);
    set_row(2, 128, 0, 0);
    one_beat("R3 lane swap", 9, 7, 130, 32'h047909FF);
  endtask

  task automatic test_foot();
    identity_rows();
    set_foot(16);
    one_beat("R4 footroom", 200, 128, 200, 32'hB80048FF);
    one_beat("R4 below footroom", 10, 255, 0, 32'h007F00FF);
  endtask

  task automatic test_round();
    set_foot(0);
    set_row(0, 1, 0, 0);
    set_row(1, -1, 0, 0);
    set_row(2, 0, 0, -512);
    one_beat("R5 round up", 64, 128, 128, 32'h010000FF);
    one_beat("R5 saturate high", 63, 128, 0, 32'h0000FFFF);
    one_beat("R5 negative clamp", 255, 128, 255, 32'h020000FF);
    one_beat("R5 half step", 192, 128, 128, 32'h020000FF);
    one_beat("R5 below half", 191, 128, 128, 32'h010000FF);
  endtask

  task automatic test_formats();
    logic [31:0] lits [4];
    lits = '{32'hFF007FFF, 32'h0000F80F, 32'h0000F81F, 32'h0000F07F};
    identity_rows();
    set_foot(0);
    for (int f = 0; f < 4; f++) begin
      set_fmt(f);
      one_beat("R6 layout", 255, 128, 255, lits[f]);
    end
    set_fmt(0);
  endtask

  task automatic test_latency();
    set_row(0, 149, 0, 204);
    set_row(1, 149, -50, -104);
    set_row(2, 149, 258, 0);
    set_foot(16);
    rdy_mode = 0;
    mon_on = 1'b1;
    @(negedge clk);
    in_valid = 1'b1; in_y = 8'd120; in_cb = 8'd90; in_cr = 8'd170;
    #9;
    chk("R7 beat taken", 32'(in_ready), 1);
    @(negedge clk);
    in_valid = 1'b0;
    #1;
    chk("R7 not yet after 1 edge", 32'(out_valid), 0);
    @(negedge clk);
    #1;
    chk("R7 not yet after 2 edges", 32'(out_valid), 0);
    @(negedge clk);
    #1;
    chk("R7 valid after 3 edges", 32'(out_valid), 1);
    repeat (5) @(negedge clk);
    mon_on = 1'b0;
  endtask

  task automatic stream(input int n, input int seed, input int mode, input int fmt);
    set_fmt(fmt);
    rdy_mode = mode;
    mon_on = 1'b1;
    @(negedge clk);
    for (int i = 0; i < n; i++) begin
      send((i * 37 + seed) & 255, (i * 91 + seed * 3) & 255, (255 - i * 53 + seed) & 255);
    end
    repeat (20) @(negedge clk);
    chk("R7 all pixels delivered", 32'(expq.size()), 0);
    mon_on = 1'b0;
    rdy_mode = 0;
  endtask

  bit done = 1'b0;

  initial begin
    #(CLK_NS * 150000);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL R7 watchdog act=running exp=finished");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    for (int r = 0; r < 3; r++)
      for (int k = 0; k < 3; k++) m_coef[r][k] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    test_reset();
    test_range();
    test_lanes();
    test_foot();
    test_round();
    test_formats();
    test_latency();
    stream(40, 5, 0, 0);
    stream(40, 17, 1, 0);
    stream(30, 99, 1, 2);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule